// File: doc/BRIEF.md
# Inbound Bus-Master Address Window Translator

This block sits on the device side of a host bridge. It turns addresses issued by bus masters into local memory addresses. Three programmable windows each start at bus address zero. A window's extent comes from a size/attribute word, and the window's local base register relocates it into local memory. A lookup port accepts a 64-bit bus address. One cycle later it returns a hit flag, the index of the winning window and the translated 64-bit local address.

Software programs the windows through a 32-bit register port. The port is shared with a neighbouring outbound unit, so this block answers only at its own fixed offsets. All 64-bit quantities are split into low and high 32-bit halves. The middle window is the exception: it has a single 32-bit size register. A small scratch status register is also held here.

Top module: `inb_xlate`

## Requirements
- R1: After reset every window is disabled. Lookups miss. Size words read back 0x00000000 on the low half and 0xFFFFFFFF on the high half. Local base halves read 0. The status register reads 0.
- R2: Register offsets are fixed as follows. Window 0: size low 0x98, size high 0xF8, base low 0x9C, base high 0xA0. Window 1: size 0xA4, base low 0xA8, base high 0xAC. Window 2: size low 0xB0, size high 0xFC, base low 0xB4, base high 0xB8. Each register reads back what was written, in the cycle after cfg_rd. Writing one half of a 64-bit quantity leaves the other half unchanged.
- R3: A write to window 1's size register at 0xA4 loads the low 32 bits of its size word and clears the upper 32 bits. Window 1 then compares only the low 32 address bits.
- R4: Bit 0 of a size word enables its window. A window with bit 0 clear never hits.
- R5: The window mask is the size word with bits 2:0 forced to zero. An address hits an enabled window when the address ANDed with the mask is zero. This means the window covers bus addresses from 0 up to the two's complement of the mask.
- R6: On a hit, lk_laddr equals the window's local base plus the address bits outside the mask.
- R7: When several windows hit, the lowest window index is reported.
- R8: On a miss, lk_hit is 0, lk_win is 0 and lk_laddr equals the requested address unchanged.
- R9: lk_ack rises exactly one cycle after lk_req, with the result. A register write is used by a lookup requested in the following cycle.
- R10: The status register at 0xE0 holds any 32-bit value written to it.
- R11: Reads from any offset not listed in R2 or R10 return 0. Writes to such offsets change no readable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid the cycle after cfg_rd |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 64 | Bus-master address to translate |
| lk_ack | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Address fell inside an enabled window |
| lk_win | output | 2 | Index of the winning window |
| lk_laddr | output | 64 | Translated local address, or the input address on a miss |

## Verification
The hardest case to reach from the ports is window 1 after its 32-bit size write. Its upper mask is then cleared, so addresses with large upper bits alias into it while the other windows reject them. The stimulus programs all three windows with overlapping sizes. It then sends addresses whose upper bits are non-zero, or whose only set bit is the top bit, and checks that window 1 wins with the upper bits carried into the local address. A later step clears window 0's enable bit and checks that priority falls to the next window in the very next lookup.

// File: rtl/inb_xlate_pkg.sv
package inb_xlate_pkg;
  parameter int ADDR_W = 64;
  parameter int REG_W  = 32;
  parameter int OFF_W  = 8;
  parameter int NWIN   = 3;
  localparam int WIN_W = $clog2(NWIN);

  typedef struct packed {
    logic [ADDR_W-1:0] size;
    logic [ADDR_W-1:0] base;
  } win_cfg_t;

  // reset: upper mask all ones, enable bit clear
  localparam logic [ADDR_W-1:0] SIZE_RST = {{REG_W{1'b1}}, {REG_W{1'b0}}};

  // per-window offsets; neighbour decodes the rest of the port
  localparam logic [OFF_W-1:0] SZ_LO_OFF [NWIN] = '{8'h98, 8'hA4, 8'hB0};
  localparam logic [OFF_W-1:0] SZ_HI_OFF [NWIN] = '{8'hF8, 8'h00, 8'hFC};
  localparam logic [OFF_W-1:0] BS_LO_OFF [NWIN] = '{8'h9C, 8'hA8, 8'hB4};
  localparam logic [OFF_W-1:0] BS_HI_OFF [NWIN] = '{8'hA0, 8'hAC, 8'hB8};
  localparam logic             HAS_SZ_HI [NWIN] = '{1'b1, 1'b0, 1'b1};
  localparam logic [OFF_W-1:0] STAT_OFF         = 8'hE0;
endpackage

// File: rtl/inb_xlate_regs.sv
module inb_xlate_regs
  import inb_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [OFF_W-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output win_cfg_t         cfg [NWIN]
);
  logic [REG_W-1:0] status_q;
  logic [REG_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWIN; i++) begin
        cfg[i].size <= SIZE_RST;
        cfg[i].base <= '0;
      end
      status_q <= '0;
    end else if (wr) begin
      for (int i = 0; i < NWIN; i++) begin
        if (addr == SZ_LO_OFF[i]) begin
          cfg[i].size[REG_W-1:0] <= wdata;
          if (!HAS_SZ_HI[i]) cfg[i].size[ADDR_W-1:REG_W] <= '0;
        end
        if (HAS_SZ_HI[i] && addr == SZ_HI_OFF[i]) cfg[i].size[ADDR_W-1:REG_W] <= wdata;
        if (addr == BS_LO_OFF[i]) cfg[i].base[REG_W-1:0]      <= wdata;
        if (addr == BS_HI_OFF[i]) cfg[i].base[ADDR_W-1:REG_W] <= wdata;
      end
      if (addr == STAT_OFF) status_q <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (addr == SZ_LO_OFF[i]) rd_mux = cfg[i].size[REG_W-1:0];
      if (HAS_SZ_HI[i] && addr == SZ_HI_OFF[i]) rd_mux = cfg[i].size[ADDR_W-1:REG_W];
      if (addr == BS_LO_OFF[i]) rd_mux = cfg[i].base[REG_W-1:0];
      if (addr == BS_HI_OFF[i]) rd_mux = cfg[i].base[ADDR_W-1:REG_W];
    end
    if (addr == STAT_OFF) rd_mux = status_q;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/inb_xlate_match.sv
module inb_xlate_match
  import inb_xlate_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] laddr
);
  logic [ADDR_W-1:0] mask;

  // low three bits never take part in the mask; bit 0 is the enable
  assign mask  = cfg.size & ~{{(ADDR_W-3){1'b0}}, 3'b111};
  assign hit   = cfg.size[0] && ((addr & mask) == '0);
  assign laddr = cfg.base + (addr & ~mask);
endmodule

// File: rtl/inb_xlate_pick.sv
module inb_xlate_pick
  import inb_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NWIN-1:0]   hit_vec,
  input  logic [ADDR_W-1:0] laddr_vec [NWIN],
  output logic              ack,
  output logic              hit,
  output logic [WIN_W-1:0]  win,
  output logic [ADDR_W-1:0] laddr
);
  logic              sel_hit;
  logic [WIN_W-1:0]  sel_win;
  logic [ADDR_W-1:0] sel_laddr;

  // walk from the top down so the lowest index is the last to assign
  always_comb begin
    sel_hit   = 1'b0;
    sel_win   = '0;
    sel_laddr = addr;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_hit   = 1'b1;
        sel_win   = WIN_W'(i);
        sel_laddr = laddr_vec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      hit   <= 1'b0;
      win   <= '0;
      laddr <= '0;
    end else begin
      ack <= req;
      if (req) begin
        hit   <= sel_hit;
        win   <= sel_win;
        laddr <= sel_laddr;
      end else begin
        hit <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/inb_xlate.sv
module inb_xlate
  import inb_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [OFF_W-1:0]  cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_ack,
  output logic              lk_hit,
  output logic [WIN_W-1:0]  lk_win,
  output logic [ADDR_W-1:0] lk_laddr
);
  win_cfg_t          cfg [NWIN];
  logic [NWIN-1:0]   hit_vec;
  logic [ADDR_W-1:0] laddr_vec [NWIN];

  inb_xlate_regs regs_i (
    .clk(clk), .rst(rst), .wr(cfg_wr), .rd(cfg_rd), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg(cfg)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    inb_xlate_match match_i (
      .cfg(cfg[g]), .addr(lk_addr), .hit(hit_vec[g]), .laddr(laddr_vec[g])
    );
  end

  inb_xlate_pick pick_i (
    .clk(clk), .rst(rst), .req(lk_req), .addr(lk_addr),
    .hit_vec(hit_vec), .laddr_vec(laddr_vec),
    .ack(lk_ack), .hit(lk_hit), .win(lk_win), .laddr(lk_laddr)
  );
endmodule

// File: rtl/inb_xlate_chk.sv
module inb_xlate_chk
  import inb_xlate_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cfg_rd,
  input logic [OFF_W-1:0]  cfg_addr,
  input logic [REG_W-1:0]  cfg_rdata,
  input logic              lk_req,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_ack,
  input logic              lk_hit,
  input logic [WIN_W-1:0]  lk_win,
  input logic [ADDR_W-1:0] lk_laddr
);
  logic known_off;
  always_comb begin
    known_off = (cfg_addr == STAT_OFF);
    for (int i = 0; i < NWIN; i++) begin
      if (cfg_addr == SZ_LO_OFF[i] || cfg_addr == BS_LO_OFF[i] ||
          cfg_addr == BS_HI_OFF[i] || (HAS_SZ_HI[i] && cfg_addr == SZ_HI_OFF[i]))
        known_off = 1'b1;
    end
  end

  a_r9_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_ack);
  a_r9_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_ack);
  a_r8_miss_passthrough: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> (lk_hit || (lk_laddr == $past(lk_addr) && lk_win == '0)));
  a_r7_win_in_range: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_ack && lk_win < WIN_W'(NWIN)));
  a_r11_undef_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && !known_off) |=> cfg_rdata == '0);
endmodule

bind inb_xlate inb_xlate_chk chk_i (
  .clk(clk), .rst(rst), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
  .cfg_rdata(cfg_rdata), .lk_req(lk_req), .lk_addr(lk_addr),
  .lk_ack(lk_ack), .lk_hit(lk_hit), .lk_win(lk_win), .lk_laddr(lk_laddr)
);

// File: tb/inb_xlate_tb_top.sv
module inb_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lk_req = 1'b0;
  logic [63:0] lk_addr = '0;
  logic        lk_ack, lk_hit;
  logic [1:0]  lk_win;
  logic [63:0] lk_laddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  inb_xlate dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_req(lk_req), .lk_addr(lk_addr),
    .lk_ack(lk_ack), .lk_hit(lk_hit), .lk_win(lk_win), .lk_laddr(lk_laddr)
  );

  typedef struct packed {
    logic [63:0] a;
    logic        h;
    logic [1:0]  w;
    logic [63:0] l;
  } vec_t;

  // window 0: 64 KiB -> 0x1_0000_0000; window 1: 4 KiB low-32 compare -> 0x8000_0000;
  // window 2: 1 MiB (bits 2:1 set, ignored) -> 0x2000_0000
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_0000_1234, 1'b1, 2'd0, 64'h0000_0001_0000_1234},
    '{64'h0000_0000_0000_FFFF, 1'b1, 2'd0, 64'h0000_0001_0000_FFFF},
    '{64'h0000_0000_0001_0000, 1'b1, 2'd2, 64'h0000_0000_2001_0000},
    '{64'h0000_0000_000F_FFF8, 1'b1, 2'd2, 64'h0000_0000_200F_FFF8},
    '{64'h0000_0000_0010_0000, 1'b0, 2'd0, 64'h0000_0000_0010_0000},
    '{64'h0000_0005_0000_0800, 1'b1, 2'd1, 64'h0000_0005_8000_0800},
    '{64'h8000_0000_0000_0000, 1'b1, 2'd1, 64'h8000_0000_8000_0000},
    '{64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic look(input string req, input logic [63:0] a, input logic h,
                      input logic [1:0] w, input logic [63:0] l);
    @(negedge clk);
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
    check({req, " ack"}, {63'b0, lk_ack}, 64'd1);
    check({req, " hit"}, {63'b0, lk_hit}, {63'b0, h});
    check({req, " win"}, {62'b0, lk_win}, {62'b0, w});
    check({req, " laddr"}, lk_laddr, l);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, {32'b0, d}, {32'b0, exp});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 ack idle", {63'b0, lk_ack}, 64'd0);
    rd_chk("R1 w0 size lo", 8'h98, 32'h0000_0000);
    rd_chk("R1 w0 size hi", 8'hF8, 32'hFFFF_FFFF);
    rd_chk("R1 w2 size hi", 8'hFC, 32'hFFFF_FFFF);
    rd_chk("R1 w1 base hi", 8'hAC, 32'h0);
    rd_chk("R1 status", 8'hE0, 32'h0);
    look("R1 all disabled", 64'h0, 1'b0, 2'd0, 64'h0);

    // R2 programming and half preservation
    wr(8'hA0, 32'h0000_0001);
    wr(8'h9C, 32'h0000_0000);
    rd_chk("R2 base hi kept", 8'hA0, 32'h0000_0001);
    wr(8'h98, 32'hFFFF_0001);
    rd_chk("R2 size hi kept", 8'hF8, 32'hFFFF_FFFF);
    rd_chk("R2 size lo", 8'h98, 32'hFFFF_0001);
    wr(8'hA8, 32'h8000_0000);
    wr(8'hA4, 32'hFFFF_F001);
    wr(8'hB4, 32'h2000_0000);
    wr(8'hB0, 32'hFFF0_0007);  // R5 bits 2:1 set but ignored
    rd_chk("R2 w2 base lo", 8'hB4, 32'h2000_0000);
    rd_chk("R3 w1 size", 8'hA4, 32'hFFFF_F001);

    // R5 R6 R7 R8 R3 table
    for (int i = 0; i < NV; i++)
      look($sformatf("R5/R6/R7/R8/R3 vec%0d", i), VECS[i].a, VECS[i].h, VECS[i].w, VECS[i].l);

    // R4 R9: disable window 0, lookup in the very next cycle falls to window 2
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'h98; cfg_wdata = 32'hFFFF_0000;
    @(negedge clk);
    cfg_wr = 1'b0;
    lk_req = 1'b1; lk_addr = 64'h1234;
    @(negedge clk);
    lk_req = 1'b0;
    check("R4 disabled hit", {63'b0, lk_hit}, 64'd1);
    check("R9 immediate win", {62'b0, lk_win}, 64'd2);
    check("R6 w2 laddr", lk_laddr, 64'h2000_1234);

    // R10 status
    wr(8'hE0, 32'hA5C3_0F96);
    rd_chk("R10 status", 8'hE0, 32'hA5C3_0F96);

    // R11 undefined offsets
    wr(8'h04, 32'hDEAD_BEEF);
    wr(8'h90, 32'hDEAD_BEEF);
    rd_chk("R11 undef 04", 8'h04, 32'h0);
    rd_chk("R11 undef 90", 8'h90, 32'h0);
    rd_chk("R11 no side effect", 8'hE0, 32'hA5C3_0F96);
    rd_chk("R11 w1 base kept", 8'hA8, 32'h8000_0000);

    // R1 again: reset clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    look("R1 after reset miss", 64'h1234, 1'b0, 2'd0, 64'h1234);
    rd_chk("R1 status cleared", 8'hE0, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule